// File: doc/BRIEF.md
# Multi-Mode Floating-Point Minimum/Maximum Unit

This unit takes two IEEE 754 double-precision operands and a 4-bit mode. It returns their minimum or maximum under one of sixteen semantics. The low two mode bits pick a base policy for NaNs and signed zeros. The other two bits pick minimum or maximum, and whether operand magnitudes are compared first. In the magnitude-first modes, ties and NaN inputs fall back to the base policy.

The operands and mode are sampled on a clock edge when `in_valid` is high. The result, a signaling-NaN exception flag and an optional 4-bit condition summary appear one cycle later and hold until the next accepted operation. The caller accumulates the exception flag into its own status state. The condition summary is produced only when the record-form request is set.

Top module: `fmm_unit`

## Requirements
- R1: Synchronous active-high reset clears `out_valid`, `result`, `snan_flag` and `cond` to zero. When `in_valid` is high at a clock edge, `out_valid` is high after that edge and the outputs show that operation. When `in_valid` is low at an edge, `out_valid` drops and `result`, `snan_flag` and `cond` keep their values.
- R2: The mode decodes as follows. Bit 3 selects maximum when set and minimum when clear. Bit 2 selects magnitude-first comparison. Bits 1:0 select the base policy: 00 number-preferring (2008 style), 01 NaN-propagating (2019 style), 10 number-preferring (2019 style), 11 C-style comparison.
- R3: Base 11 returns A if A < B (minimum) or A > B (maximum) under numeric comparison, where -0.0 equals +0.0; otherwise it returns B. A NaN operand or an equal pair therefore yields B.
- R4: Bases 00 and 10 return the other operand when exactly one operand is NaN. Between numbers they order -0.0 strictly below +0.0.
- R5: Bases 00 and 10 return 0x7FF8000000000000 when both operands are NaN.
- R6: Base 01 returns A (quietened) when A is NaN, else B (quietened) when B is NaN. Between numbers it orders -0.0 below +0.0.
- R7: In magnitude-first mode, operands are compared on bits 62:0 as unsigned integers. For minimum the smaller magnitude wins; for maximum the larger one wins. An equal magnitude or any NaN operand falls back to the base policy.
- R8: Any NaN on `result` has mantissa bit 51 set. A NaN taken from an operand keeps its other bits.
- R9: `snan_flag` is high after an accepted operation exactly when either operand is a signaling NaN: exponent bits 62:52 all ones, bits 51:0 nonzero and bit 51 clear.
- R10: With `rec_en` set, `cond` is one-hot over the result: bit 3 negative non-zero number, bit 2 positive non-zero number, bit 1 zero of either sign, bit 0 NaN. With `rec_en` clear, `cond` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept operands and mode on this edge |
| op_a | input | 64 | First operand A |
| op_b | input | 64 | Second operand B |
| mode | input | 4 | Min/max, magnitude-first and base policy select |
| rec_en | input | 1 | Request the condition summary |
| out_valid | output | 1 | Result registers hold a new operation |
| result | output | 64 | Selected operand or default NaN |
| snan_flag | output | 1 | Signaling-NaN invalid exception |
| cond | output | 4 | One-hot condition summary of the result |

## Verification
Uniform random 64-bit operands almost never give a signaling NaN, a pair of opposite-signed zeros, or two values of equal magnitude and different sign. These are the cases where the sixteen policies differ. The stimulus therefore draws each operand from weighted classes: signed zeros, infinities, quiet and signaling NaNs, and a copy of the other operand with its sign flipped. It also sweeps every mode against each class pair, so magnitude ties hand off to every fallback policy. A directed prologue pins down the default NaN, signed-zero ordering and hold behaviour with exact values.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

    localparam int FMM_EXP_W = 11;
    localparam int FMM_MAN_W = 52;
    localparam int FMM_W     = 1 + FMM_EXP_W + FMM_MAN_W;

    typedef enum logic [1:0] {
        BASE_NUM08  = 2'b00,
        BASE_PROP19 = 2'b01,
        BASE_NUM19  = 2'b10,
        BASE_CSTYLE = 2'b11
    } fmm_base_e;

    typedef struct packed {
        logic      is_max;
        logic      by_mag;
        fmm_base_e base;
    } fmm_mode_t;

    typedef struct packed {
        logic nan;
        logic snan;
        logic zero;
        logic sign;
    } fmm_class_t;

endpackage

// File: rtl/fmm_classify.sv
module fmm_classify
    import fmm_pkg::*;
#(
    parameter int EXP_W = FMM_EXP_W,
    parameter int MAN_W = FMM_MAN_W
) (
    input  logic [EXP_W+MAN_W:0] value,
    output fmm_class_t           cls
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic exp_ones;
    logic man_nz;

    always_comb begin
        exp_ones = &value[W-2:MAN_W];
        man_nz   = |value[MAN_W-1:0];
        cls.sign = value[W-1];
        cls.nan  = exp_ones && man_nz;
        cls.snan = exp_ones && man_nz && !value[MAN_W-1];
        cls.zero = ~|value[W-2:0];
    end
endmodule

// File: rtl/fmm_pick.sv
module fmm_pick
    import fmm_pkg::*;
#(
    parameter int EXP_W = FMM_EXP_W,
    parameter int MAN_W = FMM_MAN_W
) (
    input  logic [EXP_W+MAN_W:0] a,
    input  logic [EXP_W+MAN_W:0] b,
    input  fmm_class_t           cls_a,
    input  fmm_class_t           cls_b,
    input  fmm_mode_t            md,
    output logic [EXP_W+MAN_W:0] picked
);
    localparam int W = 1 + EXP_W + MAN_W;
    localparam logic [W-1:0] SIGN_BIT  = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] QUIET_BIT = {{(W-MAN_W){1'b0}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [W-1:0] DFLT_NAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic [W-1:0] key_a, key_b;
    logic         tot_lt, tot_gt;
    logic         num_lt, num_gt;
    logic [W-1:0] ordered;
    logic [W-1:0] base_res;
    logic         mag_lt, mag_gt, mag_take_a, mag_take_b;
    logic [W-1:0] raw;
    logic         raw_nan;

    // total order key: negative values reversed, positives lifted above them
    always_comb begin
        key_a  = cls_a.sign ? ~a : (a ^ SIGN_BIT);
        key_b  = cls_b.sign ? ~b : (b ^ SIGN_BIT);
        tot_lt = key_a < key_b;
        tot_gt = key_a > key_b;
        // numeric compare: unordered on NaN, zeros equal
        num_lt = !cls_a.nan && !cls_b.nan && !(cls_a.zero && cls_b.zero) && tot_lt;
        num_gt = !cls_a.nan && !cls_b.nan && !(cls_a.zero && cls_b.zero) && tot_gt;
        ordered = md.is_max ? (tot_lt ? b : a) : (tot_gt ? b : a);
    end

    always_comb begin
        unique case (md.base)
            BASE_NUM08, BASE_NUM19: begin
                if (cls_a.nan && cls_b.nan) base_res = DFLT_NAN;
                else if (cls_a.nan)         base_res = b;
                else if (cls_b.nan)         base_res = a;
                else                        base_res = ordered;
            end
            BASE_PROP19: begin
                if (cls_a.nan)      base_res = a;
                else if (cls_b.nan) base_res = b;
                else                base_res = ordered;
            end
            default: begin
                if (md.is_max) base_res = num_gt ? a : b;
                else           base_res = num_lt ? a : b;
            end
        endcase
    end

    always_comb begin
        mag_lt     = a[W-2:0] < b[W-2:0];
        mag_gt     = a[W-2:0] > b[W-2:0];
        mag_take_a = md.is_max ? mag_gt : mag_lt;
        mag_take_b = md.is_max ? mag_lt : mag_gt;
        if (md.by_mag && !cls_a.nan && !cls_b.nan && mag_take_a)      raw = a;
        else if (md.by_mag && !cls_a.nan && !cls_b.nan && mag_take_b) raw = b;
        else                                                          raw = base_res;
        raw_nan = (&raw[W-2:MAN_W]) && (|raw[MAN_W-1:0]);
        picked  = raw_nan ? (raw | QUIET_BIT) : raw;
    end
endmodule

// File: rtl/fmm_cond.sv
module fmm_cond
    import fmm_pkg::*;
#(
    parameter int EXP_W = FMM_EXP_W,
    parameter int MAN_W = FMM_MAN_W
) (
    input  logic [EXP_W+MAN_W:0] value,
    input  logic                 enable,
    output logic [3:0]           flags
);
    localparam int W = 1 + EXP_W + MAN_W;

    logic is_nan, is_zero;

    always_comb begin
        is_nan  = (&value[W-2:MAN_W]) && (|value[MAN_W-1:0]);
        is_zero = ~|value[W-2:0];
        flags   = 4'b0000;
        if (enable) begin
            flags[0] = is_nan;
            flags[1] = is_zero;
            flags[2] = !is_nan && !is_zero && !value[W-1];
            flags[3] = !is_nan && !is_zero &&  value[W-1];
        end
    end
endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
    import fmm_pkg::*;
#(
    parameter int EXP_W = FMM_EXP_W,
    parameter int MAN_W = FMM_MAN_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [EXP_W+MAN_W:0] op_a,
    input  logic [EXP_W+MAN_W:0] op_b,
    input  logic [3:0]           mode,
    input  logic                 rec_en,
    output logic                 out_valid,
    output logic [EXP_W+MAN_W:0] result,
    output logic                 snan_flag,
    output logic [3:0]           cond
);
    localparam int W = 1 + EXP_W + MAN_W;
    localparam int N_OPS = 2;
    localparam logic [W-1:0] QUIET_BIT = {{(W-MAN_W){1'b0}}, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [W-1:0] DFLT_NAN  = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic [W-1:0] ops [N_OPS];
    fmm_class_t   cls [N_OPS];
    fmm_mode_t    md;
    logic [W-1:0] picked;
    logic [3:0]   cond_next;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign md     = fmm_mode_t'(mode);

    for (genvar i = 0; i < N_OPS; i++) begin : g_cls
        fmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .value (ops[i]),
            .cls   (cls[i])
        );
    end

    fmm_pick #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_pick (
        .a      (op_a),
        .b      (op_b),
        .cls_a  (cls[0]),
        .cls_b  (cls[1]),
        .md     (md),
        .picked (picked)
    );

    fmm_cond #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cond (
        .value  (picked),
        .enable (rec_en),
        .flags  (cond_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            snan_flag <= 1'b0;
            cond      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= picked;
                snan_flag <= cls[0].snan || cls[1].snan;
                cond      <= cond_next;
            end
        end
    end

    function automatic logic [W-1:0] q_if_nan(input logic [W-1:0] x);
        if ((&x[W-2:MAN_W]) && (|x[MAN_W-1:0])) return x | QUIET_BIT;
        return x;
    endfunction

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R1
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result) && $stable(cond) && $stable(snan_flag)));

    // R2
    result_source_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (result == q_if_nan($past(op_a)) || result == q_if_nan($past(op_b))
                      || result == DFLT_NAN));

    // R8
    quiet_out_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (&result[W-2:MAN_W]) && (|result[MAN_W-1:0])) |-> result[MAN_W-1]);

    // R9
    snan_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (snan_flag && out_valid) |-> ($past(op_a[MAN_W-1]) == 1'b0 || $past(op_b[MAN_W-1]) == 1'b0));

    // R10
    cond_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(cond) <= 1);

    // R10
    cond_off_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !rec_en) |=> (cond == 4'b0000));

endmodule

// File: tb/fmm_unit_test.sv
`timescale 1ns/1ps
module fmm_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [3:0]  mode = '0;
    logic        rec_en = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        snan_flag;
    logic [3:0]  cond;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fmm_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .mode(mode), .rec_en(rec_en), .out_valid(out_valid), .result(result),
        .snan_flag(snan_flag), .cond(cond)
    );

    localparam logic [63:0] DNAN = 64'h7FF8000000000000;

    function automatic bit f_nan(input logic [63:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    endfunction

    function automatic bit f_snan(input logic [63:0] x);
        return f_nan(x) && !x[51];
    endfunction

    function automatic logic [63:0] f_quiet(input logic [63:0] x);
        return f_nan(x) ? (x | 64'h0008000000000000) : x;
    endfunction

    // numeric ordering with -0 below +0, inputs known non-NaN
    function automatic logic [63:0] f_ordered(input logic [63:0] a, input logic [63:0] b, input bit mx);
        real ra, rb;
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        if (ra < rb) return mx ? b : a;
        if (ra > rb) return mx ? a : b;
        if (a[63] != b[63]) return (a[63] ^ mx) ? a : b;
        return a;
    endfunction

    function automatic logic [63:0] f_base(input logic [63:0] a, input logic [63:0] b,
                                           input logic [1:0] base, input bit mx);
        real ra, rb;
        bit an, bn;
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        an = f_nan(a);
        bn = f_nan(b);
        case (base)
            2'b11: begin
                if (an || bn) return b;
                if (mx) return (ra > rb) ? a : b;
                return (ra < rb) ? a : b;
            end
            2'b01: begin
                if (an) return a;
                if (bn) return b;
                return f_ordered(a, b, mx);
            end
            default: begin
                if (an && bn) return DNAN;
                if (an) return b;
                if (bn) return a;
                return f_ordered(a, b, mx);
            end
        endcase
    endfunction

    function automatic logic [63:0] f_expect(input logic [63:0] a, input logic [63:0] b, input logic [3:0] m);
        logic [63:0] r;
        bit mx;
        mx = m[3];
        r = f_base(a, b, m[1:0], mx);
        if (m[2] && !f_nan(a) && !f_nan(b)) begin
            if (a[62:0] < b[62:0])      r = mx ? b : a;
            else if (a[62:0] > b[62:0]) r = mx ? a : b;
        end
        return f_quiet(r);
    endfunction

    function automatic logic [3:0] f_cond(input logic [63:0] r, input bit en);
        if (!en) return 4'b0000;
        if (f_nan(r)) return 4'b0001;
        if (r[62:0] == 0) return 4'b0010;
        return r[63] ? 4'b1000 : 4'b0100;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic [3:0] m, input bit re);
        @(negedge clk);
        op_a = a; op_b = b; mode = m; rec_en = re; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic full_check(input string req, input logic [63:0] a, input logic [63:0] b,
                              input logic [3:0] m, input bit re);
        logic [63:0] e;
        run_op(a, b, m, re);
        e = f_expect(a, b, m);
        chk(req, result, e);
        chk("R9", {63'd0, snan_flag}, {63'd0, f_snan(a) || f_snan(b)});
        chk("R10", {60'd0, cond}, {60'd0, f_cond(e, re)});
        chk("R1", {63'd0, out_valid}, 64'd1);
    endtask

    function automatic logic [63:0] gen_op(input int cls, input logic [63:0] other);
        logic [63:0] r;
        r = {$urandom, $urandom};
        case (cls)
            0: return r;
            1: return 64'h0000000000000000;
            2: return 64'h8000000000000000;
            3: return {r[63], 11'h7FF, 52'd0};
            4: return {r[63], 11'h7FF, 1'b1, r[50:0]};
            5: return {r[63], 11'h7FF, 1'b0, r[50:1], 1'b1};
            6: return {other[63] ^ 1'b1, other[62:0]};
            7: return other;
            default: return {r[63], 11'h3FF + 11'(r[3:0]), r[51:0]};
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {63'd0, out_valid}, 64'd0);
        chk("R1", result, 64'd0);
        chk("R1", {63'd0, snan_flag}, 64'd0);
        chk("R1", {60'd0, cond}, 64'd0);
        rst = 1'b0;

        // R4 signed zero ordering, minNum and maxNum
        run_op(64'h0000000000000000, 64'h8000000000000000, 4'h0, 1'b1);
        chk("R4", result, 64'h8000000000000000);
        run_op(64'h8000000000000000, 64'h0000000000000000, 4'h8, 1'b1);
        chk("R4", result, 64'h0000000000000000);
        chk("R10", {60'd0, cond}, 64'h2);
        // R4 one NaN returns the number
        run_op(64'h7FF8000000000123, 64'h3FF0000000000000, 4'h2, 1'b0);
        chk("R4", result, 64'h3FF0000000000000);
        chk("R10", {60'd0, cond}, 64'h0);
        // R5 both NaN default
        run_op(64'h7FF8000000000123, 64'hFFF0000000000007, 4'hA, 1'b1);
        chk("R5", result, DNAN);
        chk("R9", {63'd0, snan_flag}, 64'd1);
        chk("R10", {60'd0, cond}, 64'h1);
        // R3 C-style NaN and zeros give B
        run_op(64'h7FF8000000000123, 64'h4000000000000000, 4'h3, 1'b0);
        chk("R3", result, 64'h4000000000000000);
        run_op(64'h8000000000000000, 64'h0000000000000000, 4'h3, 1'b0);
        chk("R3", result, 64'h0000000000000000);
        run_op(64'h3FF0000000000000, 64'h4014000000000000, 4'hB, 1'b0);
        chk("R2", result, 64'h4014000000000000);
        // R6 and R8 NaN propagation with quieting
        run_op(64'h3FF0000000000000, 64'h7FF0000000000005, 4'h1, 1'b0);
        chk("R6", result, 64'h7FF8000000000005);
        chk("R9", {63'd0, snan_flag}, 64'd1);
        run_op(64'h7FF0000000000009, 64'h7FF8000000000123, 4'h9, 1'b0);
        chk("R8", result, 64'h7FF8000000000009);
        // R7 magnitude first and tie fallback
        run_op(64'hBFF0000000000000, 64'h4000000000000000, 4'h4, 1'b1);
        chk("R7", result, 64'hBFF0000000000000);
        chk("R10", {60'd0, cond}, 64'h8);
        run_op(64'hC008000000000000, 64'h4000000000000000, 4'hC, 1'b1);
        chk("R7", result, 64'hC008000000000000);
        run_op(64'h4000000000000000, 64'hC000000000000000, 4'h4, 1'b0);
        chk("R7", result, 64'hC000000000000000);
        run_op(64'hC000000000000000, 64'h4000000000000000, 4'hC, 1'b0);
        chk("R7", result, 64'h4000000000000000);
        chk("R9", {63'd0, snan_flag}, 64'd0);
        // R1 hold while idle
        repeat (3) @(negedge clk);
        chk("R1", result, 64'h4000000000000000);
        chk("R1", {63'd0, out_valid}, 64'd0);

        // R2 every mode across class pairs, then random mix
        for (int m = 0; m < 16; m++) begin
            for (int ca = 0; ca < 9; ca++) begin
                for (int cb = 0; cb < 9; cb++) begin
                    logic [63:0] a, b;
                    a = gen_op((ca == 6 || ca == 7) ? 0 : ca, 64'd0);
                    b = gen_op(cb, a);
                    full_check("R2", a, b, 4'(m), 1'(($urandom % 2)));
                end
            end
        end
        for (int n = 0; n < 1500; n++) begin
            logic [63:0] a, b;
            a = gen_op($urandom % 9, 64'd0);
            b = gen_op($urandom % 9, a);
            full_check("R7", a, b, 4'($urandom), 1'($urandom));
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule